// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that copies 32-bit words from a source address to a target address over one bus-master port. Software programs it through five registers: a control/status word and four shadow registers (next-descriptor pointer, source, target, command). The command word carries the remaining byte count and the per-transfer options: address stepping on each side, flow control, burst size and interrupt enables.

There are two ways to start it. In chained mode the channel reads a four-word descriptor from memory (next pointer, source, target, command, in that order, from a 16-byte aligned address), performs that transfer, and then either follows the next pointer or stops when bit 1 of the next pointer is set. In single-shot mode the channel does not fetch anything: it performs the transfer already held in its shadow registers and then stops. With flow control enabled, each assertion of the peripheral request input lets one burst through. A bus error response halts the channel at once.

Top module: `dmac_channel`

## Requirements
- R1: After reset the control/status word reads 0x00000008 (stopped bit 3 set, run bit 31 clear, flags 2:0 clear), no bus request is raised and the interrupt output is low.
- R2: Writing the control/status word with bit 31 (run) and bit 30 (single-shot) set copies the byte count in command bits 12:0 as 32-bit words (4 bytes per word, one read then one write per word), then sets the completion flag (bit 2), clears run and returns to stopped; the fetch flag (bit 1) stays clear.
- R3: Command bit 31 steps the source address by 4 after each word and bit 30 steps the target address by 4; with a bit clear that side uses the same address for every word.
- R4: Starting with bit 30 clear reads four words from the address in the next-pointer register with bits 3:0 forced to zero, loads them into next pointer, source, target and command in that order, and sets the fetch flag (bit 1).
- R5: After finishing a fetched descriptor the channel fetches the next one from the loaded next pointer (bits 3:0 zeroed) when its bit 1 is clear, and stops when its bit 1 is set.
- R6: With command bit 29 or bit 28 set, the channel moves data only after sampling the request input high, and then moves one burst: command bits 17:16 equal to 1, 2 or 3 give 8, 16 or 32 bytes (2, 4 or 8 words), 0 gives one word.
- R7: A bus error response sets the error flag (bit 0), clears run, stops the channel and leaves the remaining byte count in command bits 12:0 unchanged.
- R8: Writing 1 to any of control/status bits 2:0 clears that flag; writing 0 leaves it as it is.
- R9: Clearing run while the channel is active brings it to the stopped state with no further bus requests and without setting the completion flag.
- R10: The interrupt output is high while the error flag is set, or the completion flag is set and command bit 21 was set at completion, or the fetch flag is set and command bit 22 was set in the fetched descriptor; it is low otherwise.
- R11: A transfer with a byte count of zero completes without any data access.
- R12: Once raised, a bus request holds its address, direction and write data unchanged until the acknowledge or error response, and a new request is never issued while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index: 0 control/status, 1 next pointer, 2 source, 3 target, 4 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_idx, valid one cycle after the index |
| irq | output | 1 | Registered interrupt request |
| dreq | input | 1 | Peripheral request for flow-controlled transfers |
| bm_req | output | 1 | Bus request, held until acknowledge or error |
| bm_we | output | 1 | Bus direction, 1 for write |
| bm_addr | output | 32 | Bus byte address |
| bm_wdata | output | 32 | Bus write data |
| bm_ack | input | 1 | Bus acknowledge, completes the access |
| bm_err | input | 1 | Bus error response, ends the access |
| bm_rdata | input | 32 | Bus read data, valid with bm_ack |

## Verification
The assertions watch the bus handshake on every cycle: a pending request stays frozen until its response, no request overlaps another, the stopped state never holds a request, an error response leads to the stopped state two cycles later with the byte count untouched, and the fetch flag can only rise out of a descriptor read. Data movement, address stepping, chain following, burst sizing under the request input, flag clearing and interrupt gating depend on memory contents and on the order of events, so only the directed scenarios of the bench, which compare memory and register contents against values worked out in advance, can show them.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_FWAIT,
    S_LOADED,
    S_REQWAIT,
    S_RD,
    S_RWAIT,
    S_WR,
    S_WWAIT,
    S_DONE
  } dmac_state_e;

  // control/status bit positions (software decodes these)
  localparam int CSR_RUN     = 31;
  localparam int CSR_SINGLE  = 30;
  localparam int CSR_STOPPED = 3;
  localparam int CSR_DONE    = 2;
  localparam int CSR_LOADED  = 1;
  localparam int CSR_BUSERR  = 0;

  // command word bit positions (fetched from memory)
  localparam int CMD_STEP_SRC  = 31;
  localparam int CMD_STEP_DST  = 30;
  localparam int CMD_PACE_SRC  = 29;
  localparam int CMD_PACE_DST  = 28;
  localparam int CMD_IEN_LOAD  = 22;
  localparam int CMD_IEN_DONE  = 21;
  localparam int CMD_BURST_LO  = 16;

  // next-pointer word: halt after this descriptor
  localparam int NXT_HALT = 1;

  // register indices
  localparam logic [2:0] RIX_CSR  = 3'd0;
  localparam logic [2:0] RIX_NEXT = 3'd1;
  localparam logic [2:0] RIX_SRC  = 3'd2;
  localparam logic [2:0] RIX_DST  = 3'd3;
  localparam logic [2:0] RIX_CMD  = 3'd4;

endpackage

// File: rtl/dmac_xfer_math.sv
module dmac_xfer_math #(
  parameter int AW         = 32,
  parameter int LEN_W      = 13,
  parameter int WORD_BYTES = 4,
  parameter int BEAT_W     = 4
) (
  input  logic [AW-1:0]     src,
  input  logic [AW-1:0]     dst,
  input  logic [31:0]       cmd,
  output logic [AW-1:0]     nxt_src,
  output logic [AW-1:0]     nxt_dst,
  output logic [LEN_W-1:0]  nxt_len,
  output logic              len_zero,
  output logic              paced,
  output logic [BEAT_W-1:0] burst_beats
);
  import dmac_pkg::*;

  logic [LEN_W-1:0] len;
  logic [1:0]       bsel;

  assign len  = cmd[LEN_W-1:0];
  assign bsel = cmd[CMD_BURST_LO+1:CMD_BURST_LO];

  always_comb begin
    nxt_src  = cmd[CMD_STEP_SRC] ? src + AW'(WORD_BYTES) : src;
    nxt_dst  = cmd[CMD_STEP_DST] ? dst + AW'(WORD_BYTES) : dst;
    nxt_len  = (len > LEN_W'(WORD_BYTES)) ? len - LEN_W'(WORD_BYTES) : '0;
    len_zero = (len == '0);
    paced    = cmd[CMD_PACE_SRC] | cmd[CMD_PACE_DST];
    unique case (bsel)
      2'd1:    burst_beats = BEAT_W'(8 / WORD_BYTES);
      2'd2:    burst_beats = BEAT_W'(16 / WORD_BYTES);
      2'd3:    burst_beats = BEAT_W'(32 / WORD_BYTES);
      default: burst_beats = BEAT_W'(1);
    endcase
  end

endmodule

// File: rtl/dmac_bus_if.sv
module dmac_bus_if #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          iss_we,
  input  logic [AW-1:0] iss_addr,
  input  logic [DW-1:0] iss_wdata,
  output logic          done,
  output logic          fail,
  output logic [DW-1:0] rdata,
  output logic          bm_req,
  output logic          bm_we,
  output logic [AW-1:0] bm_addr,
  output logic [DW-1:0] bm_wdata,
  input  logic          bm_ack,
  input  logic          bm_err,
  input  logic [DW-1:0] bm_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bm_req <= 1'b0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (bm_req) begin
        if (bm_ack || bm_err) begin
          bm_req <= 1'b0;
          done   <= bm_ack && !bm_err;
          fail   <= bm_err;
        end
      end else if (issue) begin
        bm_req <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!bm_req && issue) begin
      bm_we    <= iss_we;
      bm_addr  <= iss_addr;
      bm_wdata <= iss_wdata;
    end
    if (bm_req && bm_ack) rdata <= bm_rdata;
  end

  // R12: a pending request is frozen until its response
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    bm_req && !bm_ack && !bm_err |=> bm_req && $stable(bm_addr) && $stable(bm_we) && $stable(bm_wdata));

  // R12: no new access while one is outstanding
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
    issue |-> !bm_req);

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LEN_W = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic          dreq,
  output logic          bm_req,
  output logic          bm_we,
  output logic [AW-1:0] bm_addr,
  output logic [DW-1:0] bm_wdata,
  input  logic          bm_ack,
  input  logic          bm_err,
  input  logic [DW-1:0] bm_rdata
);
  import dmac_pkg::*;

  localparam int WORD_BYTES = DW / 8;
  localparam int BEAT_W     = $clog2(32 / WORD_BYTES + 1);

  dmac_state_e st_q;

  logic              run_q, single_q;
  logic              f_done, f_load, f_err;
  logic              ien_done, ien_load;
  logic [AW-1:0]     next_q, src_q, dst_q, fbase_q;
  logic [31:0]       cmd_q;
  logic [1:0]        widx_q;
  logic [DW-1:0]     data_q;
  logic [BEAT_W-1:0] beat_q;

  logic              w_csr, idle;
  logic              issue, iss_we;
  logic [AW-1:0]     iss_addr;
  logic              bus_done, bus_fail;
  logic [DW-1:0]     bus_rdata;

  logic [AW-1:0]     nxt_src, nxt_dst;
  logic [LEN_W-1:0]  nxt_len;
  logic              len_zero, paced;
  logic [BEAT_W-1:0] burst_beats;
  logic [31:0]       csr_view;

  assign w_csr = reg_we && (reg_idx == RIX_CSR);
  assign idle  = (st_q == S_IDLE);

  dmac_xfer_math #(
    .AW(AW), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES), .BEAT_W(BEAT_W)
  ) u_math (
    .src(src_q), .dst(dst_q), .cmd(cmd_q),
    .nxt_src(nxt_src), .nxt_dst(nxt_dst), .nxt_len(nxt_len),
    .len_zero(len_zero), .paced(paced), .burst_beats(burst_beats)
  );

  always_comb begin
    issue    = 1'b0;
    iss_we   = 1'b0;
    iss_addr = src_q;
    unique case (st_q)
      S_FETCH: begin
        issue    = run_q;
        iss_addr = fbase_q | {{(AW-4){1'b0}}, widx_q, 2'b00};
      end
      S_RD: issue = run_q;
      S_WR: begin
        issue    = 1'b1;
        iss_we   = 1'b1;
        iss_addr = dst_q;
      end
      default: ;
    endcase
  end

  dmac_bus_if #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst),
    .issue(issue), .iss_we(iss_we), .iss_addr(iss_addr), .iss_wdata(data_q),
    .done(bus_done), .fail(bus_fail), .rdata(bus_rdata),
    .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_ack(bm_ack), .bm_err(bm_err), .bm_rdata(bm_rdata)
  );

  always_comb begin
    csr_view              = '0;
    csr_view[CSR_RUN]     = run_q;
    csr_view[CSR_SINGLE]  = single_q;
    csr_view[CSR_STOPPED] = idle;
    csr_view[CSR_DONE]    = f_done;
    csr_view[CSR_LOADED]  = f_load;
    csr_view[CSR_BUSERR]  = f_err;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_idx)
        RIX_CSR:  reg_rdata <= csr_view;
        RIX_NEXT: reg_rdata <= next_q;
        RIX_SRC:  reg_rdata <= src_q;
        RIX_DST:  reg_rdata <= dst_q;
        RIX_CMD:  reg_rdata <= cmd_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      run_q    <= 1'b0;
      single_q <= 1'b0;
      f_done   <= 1'b0;
      f_load   <= 1'b0;
      f_err    <= 1'b0;
      ien_done <= 1'b0;
      ien_load <= 1'b0;
      irq      <= 1'b0;
      next_q   <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cmd_q    <= '0;
      fbase_q  <= '0;
      widx_q   <= '0;
      data_q   <= '0;
      beat_q   <= '0;
    end else begin
      irq <= f_err | (f_done & ien_done) | (f_load & ien_load);

      // write-one-to-clear; a set by the sequencer below wins
      if (w_csr) begin
        if (reg_wdata[CSR_DONE])   f_done <= 1'b0;
        if (reg_wdata[CSR_LOADED]) f_load <= 1'b0;
        if (reg_wdata[CSR_BUSERR]) f_err  <= 1'b0;
      end

      unique case (st_q)
        S_IDLE: if (run_q) begin
          if (single_q) st_q <= S_LOADED;
          else begin
            fbase_q <= {next_q[AW-1:4], 4'b0000};
            widx_q  <= 2'd0;
            st_q    <= S_FETCH;
          end
        end
        S_FETCH: st_q <= run_q ? S_FWAIT : S_IDLE;
        S_FWAIT: begin
          if (bus_fail) begin
            f_err <= 1'b1;
            run_q <= 1'b0;
            st_q  <= S_IDLE;
          end else if (bus_done) begin
            unique case (widx_q)
              2'd0: next_q <= bus_rdata;
              2'd1: src_q  <= bus_rdata;
              2'd2: dst_q  <= bus_rdata;
              default: cmd_q <= bus_rdata;
            endcase
            if (widx_q == 2'd3) begin
              f_load   <= 1'b1;
              ien_load <= bus_rdata[CMD_IEN_LOAD];
              st_q     <= S_LOADED;
            end else begin
              widx_q <= widx_q + 2'd1;
              st_q   <= S_FETCH;
            end
          end
        end
        S_LOADED: begin
          if (!run_q)        st_q <= S_IDLE;
          else if (len_zero) st_q <= S_DONE;
          else if (paced)    st_q <= S_REQWAIT;
          else begin
            beat_q <= burst_beats;
            st_q   <= S_RD;
          end
        end
        S_REQWAIT: begin
          if (!run_q) st_q <= S_IDLE;
          else if (dreq) begin
            beat_q <= burst_beats;
            st_q   <= S_RD;
          end
        end
        S_RD: st_q <= run_q ? S_RWAIT : S_IDLE;
        S_RWAIT: begin
          if (bus_fail) begin
            f_err <= 1'b1;
            run_q <= 1'b0;
            st_q  <= S_IDLE;
          end else if (bus_done) begin
            data_q <= bus_rdata;
            st_q   <= S_WR;
          end
        end
        S_WR: st_q <= S_WWAIT;
        S_WWAIT: begin
          if (bus_fail) begin
            f_err <= 1'b1;
            run_q <= 1'b0;
            st_q  <= S_IDLE;
          end else if (bus_done) begin
            src_q              <= nxt_src;
            dst_q              <= nxt_dst;
            cmd_q[LEN_W-1:0]   <= nxt_len;
            beat_q             <= beat_q - BEAT_W'(1);
            if (nxt_len == '0)                        st_q <= S_DONE;
            else if (paced && beat_q == BEAT_W'(1))   st_q <= S_REQWAIT;
            else                                      st_q <= S_RD;
          end
        end
        S_DONE: begin
          f_done   <= 1'b1;
          ien_done <= cmd_q[CMD_IEN_DONE];
          if (single_q || next_q[NXT_HALT] || !run_q) begin
            run_q <= 1'b0;
            st_q  <= S_IDLE;
          end else begin
            fbase_q <= {next_q[AW-1:4], 4'b0000};
            widx_q  <= 2'd0;
            st_q    <= S_FETCH;
          end
        end
        default: st_q <= S_IDLE;
      endcase

      if (w_csr) begin
        run_q <= reg_wdata[CSR_RUN];
        if (idle) single_q <= reg_wdata[CSR_SINGLE];
      end
      if (reg_we && idle) begin
        unique case (reg_idx)
          RIX_NEXT: next_q <= reg_wdata;
          RIX_SRC:  src_q  <= reg_wdata;
          RIX_DST:  dst_q  <= reg_wdata;
          RIX_CMD:  cmd_q  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // R7: an error response reaches the stopped state two cycles later
  a_r7_err_stops: assert property (@(posedge clk) disable iff (rst)
    bm_req && bm_err |=> ##1 (st_q == S_IDLE));

  // R7: the byte count is not consumed by a failed access
  a_r7_len_kept: assert property (@(posedge clk) disable iff (rst)
    bm_req && bm_err |=> $stable(cmd_q[LEN_W-1:0]));

  // R9: the stopped state never holds a bus request
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE) |-> !bm_req);

  // R4: the fetch flag only rises out of a descriptor read
  a_r4_load_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(f_load) |-> $past(st_q) == S_FWAIT);

  // R5: a descriptor carrying the halt bit ends the chain
  a_r5_halt: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DONE) && next_q[NXT_HALT] |=> (st_q == S_IDLE));

  // R10: an error flag always raises the interrupt
  a_r10_err_irq: assert property (@(posedge clk) disable iff (rst)
    f_err |=> irq);

endmodule

// File: tb/dmac_channel_bench.sv
`timescale 1ns/1ps
module dmac_channel_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        dreq = 1'b0;
  logic        bm_req, bm_we;
  logic [31:0] bm_addr, bm_wdata;
  logic        bm_ack = 1'b0;
  logic        bm_err = 1'b0;
  logic [31:0] bm_rdata = '0;

  logic [31:0] mem [0:255];
  int          acc_cnt = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          n_cmp = 0;
  int          n_bad = 0;

  localparam logic [31:0] STEP_S = 32'h8000_0000;
  localparam logic [31:0] STEP_D = 32'h4000_0000;
  localparam logic [31:0] PACE_S = 32'h2000_0000;
  localparam logic [31:0] IEN_L  = 32'h0040_0000;
  localparam logic [31:0] IEN_D  = 32'h0020_0000;
  localparam logic [31:0] BURST8 = 32'h0001_0000;
  localparam logic [31:0] GO     = 32'h8000_0000;
  localparam logic [31:0] SINGLE = 32'h4000_0000;

  always #2 clk = ~clk;

  dmac_channel u_dmac_channel (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .dreq(dreq),
    .bm_req(bm_req), .bm_we(bm_we), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_ack(bm_ack), .bm_err(bm_err), .bm_rdata(bm_rdata)
  );

  // memory responder: answers a pending request at the falling edge
  always @(negedge clk) begin
    bm_ack = 1'b0;
    bm_err = 1'b0;
    if (bm_req) begin
      if (err_en && bm_addr == err_addr) bm_err = 1'b1;
      else begin
        bm_ack = 1'b1;
        acc_cnt++;
        if (bm_we) mem[bm_addr[9:2]] = bm_wdata;
        else       bm_rdata = mem[bm_addr[9:2]];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    reg_idx = idx;
    @(posedge clk);
    @(negedge clk);
    val = reg_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    bit ok = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && !ok; i++) begin
      rd(3'd0, v);
      ok = v[3];
    end
    if (!ok) begin
      n_bad++;
      $display("FAIL wait_stop: actual running expected stopped");
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) mem[8'h40 + i] = 32'hA000_0000 + i;
  endtask

  task automatic single_xfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr(3'd2, s); wr(3'd3, d); wr(3'd4, c);
    wr(3'd0, GO | SINGLE);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v);
    chk("R1 csr after reset", v, 32'h0000_0008);
    chk("R1 no bus request", {31'b0, bm_req}, 32'd0);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int a0;
    init_mem();
    a0 = acc_cnt;
    single_xfer(32'h100, 32'h200, STEP_S | STEP_D | IEN_D | 32'd16);
    wait_stop();
    for (int i = 0; i < 4; i++) chk("R2 copied word", mem[8'h80 + i], 32'hA000_0000 + i);
    chk("R2 access count", acc_cnt - a0, 32'd8);
    rd(3'd0, v);
    chk("R2 csr done, run clear, no fetch flag", v, 32'h4000_000C);
    chk("R10 irq on completion with enable", {31'b0, irq}, 32'd1);
    wr(3'd0, 32'h0000_0003);
    rd(3'd0, v);
    chk("R8 writing 0 keeps done flag", v, 32'h0000_000C);
    wr(3'd0, 32'h0000_0004);
    rd(3'd0, v);
    chk("R8 writing 1 clears done flag", v, 32'h0000_0008);
    repeat (2) @(negedge clk);
    chk("R10 irq low after clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_step();
    init_mem();
    single_xfer(32'h100, 32'h200, STEP_D | 32'd12);
    wait_stop();
    for (int i = 0; i < 3; i++) chk("R3 fixed source", mem[8'h80 + i], 32'hA000_0000);
    chk("R3 no write past count", mem[8'h83], 32'd0);
    single_xfer(32'h100, 32'h2F0, STEP_S | 32'd12);
    wait_stop();
    chk("R3 fixed target holds last word", mem[8'hBC], 32'hA000_0002);
    chk("R3 fixed target neighbour untouched", mem[8'hBD], 32'd0);
    wr(3'd0, 32'h0000_0007);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int a0;
    init_mem();
    mem[0] = 32'h0000_0010; mem[1] = 32'h100; mem[2] = 32'h200; mem[3] = STEP_S | STEP_D | IEN_L | 32'd8;
    mem[4] = 32'h0000_0002; mem[5] = 32'h110; mem[6] = 32'h210; mem[7] = STEP_S | STEP_D | 32'd8;
    a0 = acc_cnt;
    wr(3'd1, 32'h0000_0000);
    wr(3'd0, GO);
    wait_stop();
    chk("R5 first descriptor word 0", mem[8'h80], 32'hA000_0000);
    chk("R5 first descriptor word 1", mem[8'h81], 32'hA000_0001);
    chk("R5 second descriptor word 0", mem[8'h84], 32'hA000_0004);
    chk("R5 second descriptor word 1", mem[8'h85], 32'hA000_0005);
    chk("R5 chain access count", acc_cnt - a0, 32'd16);
    rd(3'd1, v);
    chk("R4 next pointer loaded", v, 32'h0000_0002);
    rd(3'd2, v);
    chk("R4 source loaded and stepped", v, 32'h0000_0118);
    rd(3'd0, v);
    chk("R4 csr fetch and done flags", v, 32'h0000_000E);
    chk("R10 irq gated off by last descriptor", {31'b0, irq}, 32'd0);
    wr(3'd0, 32'h0000_0007);
  endtask

  task automatic t_pace();
    logic [31:0] v;
    int a0;
    init_mem();
    a0 = acc_cnt;
    single_xfer(32'h100, 32'h200, STEP_S | STEP_D | PACE_S | BURST8 | 32'd16);
    repeat (20) @(negedge clk);
    chk("R6 no access without request", acc_cnt - a0, 32'd0);
    rd(3'd0, v);
    chk("R6 still running", {31'b0, v[3]}, 32'd0);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (30) @(negedge clk);
    chk("R6 one burst of two words", acc_cnt - a0, 32'd4);
    chk("R6 third word not yet moved", mem[8'h82], 32'd0);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    wait_stop();
    chk("R6 second burst completes", acc_cnt - a0, 32'd8);
    chk("R6 last word moved", mem[8'h83], 32'hA000_0003);
    wr(3'd0, 32'h0000_0007);
  endtask

  task automatic t_error();
    logic [31:0] v;
    init_mem();
    err_en = 1'b1; err_addr = 32'h108;
    single_xfer(32'h100, 32'h200, STEP_S | STEP_D | 32'd16);
    wait_stop();
    err_en = 1'b0;
    rd(3'd0, v);
    chk("R7 csr error, run clear", v, 32'h4000_0009);
    rd(3'd4, v);
    chk("R7 remaining count kept", v & 32'h1FFF, 32'd8);
    chk("R7 earlier word moved", mem[8'h81], 32'hA000_0001);
    chk("R7 failed word not written", mem[8'h82], 32'd0);
    chk("R10 irq on error", {31'b0, irq}, 32'd1);
    wr(3'd0, 32'h0000_0001);
    repeat (2) @(negedge clk);
    rd(3'd0, v);
    chk("R8 error flag cleared", v, 32'h0000_0008);
    chk("R10 irq low after error clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    int a0;
    init_mem();
    single_xfer(32'h100, 32'h200, STEP_S | STEP_D | PACE_S | 32'd16);
    repeat (10) @(negedge clk);
    a0 = acc_cnt;
    wr(3'd0, 32'h0000_0000);
    repeat (4) @(negedge clk);
    rd(3'd0, v);
    chk("R9 stopped after run cleared", {31'b0, v[3]}, 32'd1);
    chk("R9 no completion flag", {31'b0, v[2]}, 32'd0);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 no access after stop", acc_cnt - a0, 32'd0);
    wr(3'd0, 32'h0000_0000);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int a0;
    init_mem();
    a0 = acc_cnt;
    single_xfer(32'h100, 32'h200, STEP_S | STEP_D | IEN_D);
    wait_stop();
    chk("R11 no data access", acc_cnt - a0, 32'd0);
    rd(3'd0, v);
    chk("R11 completes with done flag", v, 32'h4000_000C);
    chk("R11 irq on zero-length completion", {31'b0, irq}, 32'd1);
    wr(3'd0, 32'h0000_0007);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    init_mem();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_step();
    t_chain();
    t_pace();
    t_error();
    t_halt();
    t_zero();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule